// File: doc/BRIEF.md
# Gated Prescaled Period Timer

This block is a 16-bit up-counter that advances once per prescaled tick. It compares its value with a period register. When the two are equal it returns to zero and raises a sticky event flag, which software can use as an interrupt request. The count source can be one of three things: every cycle of the system clock, the system clock only while an external pin is high (gated accumulation), or rising edges on that same external pin. A pin edge is detected either after a two-flop synchronizer or straight from the raw pin. Everything runs on a single clock and advances through clock-enable pulses.

Software reaches three registers through a small write/read port: control, count and period. Each register has four write operations: plain write, clear-bits, set-bits and toggle-bits. The last three change only the bits selected by the write data, so read-modify-write sequences are not needed.

Top module: `gated_timer`

## Requirements
- R1: After reset the count reads 0, the period reads 0xFFFF, the control register reads 0 and `event_flag` is low.
- R2: While the run bit (control bit 0) is 0, the count does not change unless software writes it.
- R3: With the internal source selected (control bit 1 = 0, gate bit 2 = 0) and the prescale field at 00, the count rises by one on every clock cycle in which the timer runs.
- R4: The prescale field (control bits 5:4) selects the number of source pulses per tick: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256.
- R5: Outside gated mode, a tick that finds the count equal to the period loads 0 into the count and sets the event flag.
- R6: With the period at 0 outside gated mode, the count stays at 0 and the flag is set on every tick.
- R7: The event flag is control bit 6 and drives `event_flag`. It stays set until software clears it. A hardware set in the same cycle as a software clear wins.
- R8: Write address bits 3:2 select the register (00 control, 01 count, 10 period). Bits 1:0 select the operation (00 write, 01 clear the masked bits, 10 set the masked bits, 11 invert the masked bits). Read address 00/01/10 returns the same registers.
- R9: In gated mode (control bit 2 = 1, bit 1 = 0), the count advances only on cycles where the synchronized `ext_pin` is high. A period match does not reset the count. The flag is set when the synchronized pin falls.
- R10: With the external source and sync enabled (control bits 1 and 3 = 1), each rising edge of `ext_pin` is one source pulse after a two-flop synchronizer.
- R11: With the external source and sync disabled (bit 3 = 0), each rising edge of `ext_pin` is one source pulse taken from the raw pin.
- R12: A write to the count register, or a control write whose mask covers the prescale field, clears the prescaler's internal counter.
- R13: A software write to the count takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Write address: register in 3:2, operation in 1:0 |
| bus_wdata | input | 16 | Write data or bit mask |
| bus_raddr | input | 2 | Read register select |
| bus_rdata | output | 16 | Read data (combinational) |
| ext_pin | input | 1 | External clock or gate input |
| event_flag | output | 1 | Sticky period/gate event flag |

## Verification
Several rules are checked by assertions on every cycle:
- the count holds while stopped;
- a tick at a match returns the count to zero and sets the flag;
- a zero period keeps the count at zero;
- the flag persists without a software write;
- a gated-mode tick always steps the count by exactly one;
- the prescaler counter never exceeds its selected limit.

Other behaviours can only be shown by the directed scenarios:
- the exact divide ratios;
- the synchronizer latency that makes a gate window of N cycles count exactly N;
- the alias arithmetic;
- the priority of software writes over hardware updates in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PRESC_W = 8;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_CLEAR  = 2'b01,
    OP_SET    = 2'b10,
    OP_INVERT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RG_CTRL   = 2'b00,
    RG_COUNT  = 2'b01,
    RG_PERIOD = 2'b10,
    RG_NONE   = 2'b11
  } reg_e;

  // Packed LSB-last: run is bit 0, prescale is bits 5:4.
  typedef struct packed {
    logic [1:0] ps;
    logic       sync_ext;
    logic       gate_mode;
    logic       src_ext;
    logic       run;
  } ctrl_t;

  function automatic logic [PRESC_W-1:0] presc_limit(input logic [1:0] ps);
    case (ps)
      2'b00:   presc_limit = PRESC_W'(0);
      2'b01:   presc_limit = PRESC_W'(7);
      2'b10:   presc_limit = PRESC_W'(63);
      default: presc_limit = PRESC_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level,
  output logic rise,
  output logic fall
);

  logic prev_q;

  generate
    if (STAGES == 0) begin : g_raw
      assign level = pin_in;
    end else begin : g_sync
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_in};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign level = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [1:0] ps,
  output logic       tick
);

  logic [PRESC_W-1:0] pcnt_q, pcnt_d, lim;

  always_comb begin
    lim    = presc_limit(ps);
    tick   = en & ~clr & (pcnt_q == lim);
    pcnt_d = pcnt_q;
    if (clr)       pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else if (en)   pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assert_pcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= lim);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [3:0]    waddr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    raddr,
  output logic [DW-1:0] rdata,
  input  logic          hw_cnt_en,
  input  logic [DW-1:0] hw_cnt_val,
  input  logic          hw_flag_set,
  output ctrl_t         ctrl,
  output logic [DW-1:0] count,
  output logic [DW-1:0] period,
  output logic          flag,
  output logic          cnt_sw_wr,
  output logic          presc_clr
);

  localparam int CWW = $bits(ctrl_t) + 1;

  function automatic logic [DW-1:0] apply_w(op_e op, logic [DW-1:0] cur, logic [DW-1:0] m);
    case (op)
      OP_WRITE:  apply_w = m;
      OP_CLEAR:  apply_w = cur & ~m;
      OP_SET:    apply_w = cur | m;
      default:   apply_w = cur ^ m;
    endcase
  endfunction

  function automatic logic [CWW-1:0] apply_c(op_e op, logic [CWW-1:0] cur, logic [CWW-1:0] m);
    case (op)
      OP_WRITE:  apply_c = m;
      OP_CLEAR:  apply_c = cur & ~m;
      OP_SET:    apply_c = cur | m;
      default:   apply_c = cur ^ m;
    endcase
  endfunction

  ctrl_t          ctrl_q, ctrl_d;
  logic           flag_q, flag_d;
  logic [DW-1:0]  count_q, count_d, period_q, period_d;
  logic [CWW-1:0] ctrl_word, ctrl_new;
  op_e            op;
  reg_e           rsel;
  logic           ctrl_wr, per_wr;

  always_comb begin
    op        = op_e'(waddr[1:0]);
    rsel      = reg_e'(waddr[3:2]);
    ctrl_wr   = we && (rsel == RG_CTRL);
    cnt_sw_wr = we && (rsel == RG_COUNT);
    per_wr    = we && (rsel == RG_PERIOD);
    ctrl_word = {flag_q, ctrl_q};
    ctrl_new  = apply_c(op, ctrl_word, wdata[CWW-1:0]);
    presc_clr = cnt_sw_wr | (ctrl_wr && ((op == OP_WRITE) || (wdata[5:4] != 2'b00)));

    ctrl_d   = ctrl_wr ? ctrl_t'(ctrl_new[CWW-2:0]) : ctrl_q;
    flag_d   = (ctrl_wr ? ctrl_new[CWW-1] : flag_q) | hw_flag_set;
    period_d = per_wr ? apply_w(op, period_q, wdata) : period_q;
    count_d  = count_q;
    if (cnt_sw_wr)      count_d = apply_w(op, count_q, wdata);
    else if (hw_cnt_en) count_d = hw_cnt_val;

    case (raddr)
      2'b00:   rdata = DW'(ctrl_word);
      2'b01:   rdata = count_q;
      2'b10:   rdata = period_q;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      count_q  <= '0;
      period_q <= '1;
    end else begin
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
      count_q  <= count_d;
      period_q <= period_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign count  = count_q;
  assign period = period_q;
  assign flag   = flag_q;

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ctrl_wr) |=> flag_q);

  assert_sw_count_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sw_wr && op == OP_WRITE) |=> (count_q == $past(wdata)));

endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [3:0]       bus_waddr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic [1:0]       bus_raddr,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_pin,
  output logic             event_flag
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] count, period, next_val;
  logic             flag, cnt_sw_wr, presc_clr;
  logic             s_level, s_rise, s_fall;
  logic             r_level, r_rise, r_fall;
  logic             gated, src_pulse, tick, match, flag_set;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(ext_pin),
    .level(s_level), .rise(s_rise), .fall(s_fall)
  );

  tmr_edge_sync #(.STAGES(0)) i_raw_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(ext_pin),
    .level(r_level), .rise(r_rise), .fall(r_fall)
  );

  always_comb begin
    gated = ~ctrl.src_ext & ctrl.gate_mode;
    if (ctrl.src_ext)        src_pulse = ctrl.sync_ext ? s_rise : r_rise;
    else if (ctrl.gate_mode) src_pulse = s_level;
    else                     src_pulse = 1'b1;
  end

  tmr_prescaler i_presc (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl.run & src_pulse), .clr(presc_clr),
    .ps(ctrl.ps), .tick(tick)
  );

  always_comb begin
    match    = (count == period);
    next_val = (!gated && match) ? '0 : count + 1'b1;
    flag_set = ctrl.run & ((tick & ~gated & match) | (gated & s_fall));
  end

  tmr_regs #(.DW(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .we(bus_we), .waddr(bus_waddr), .wdata(bus_wdata),
    .raddr(bus_raddr), .rdata(bus_rdata),
    .hw_cnt_en(tick), .hw_cnt_val(next_val), .hw_flag_set(flag_set),
    .ctrl(ctrl), .count(count), .period(period), .flag(flag),
    .cnt_sw_wr(cnt_sw_wr), .presc_clr(presc_clr)
  );

  assign event_flag = flag;

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !cnt_sw_wr) |=> $stable(count));

  assert_match_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gated && count == period && !cnt_sw_wr) |=> (count == '0 && event_flag));

  assert_zero_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0 && count == '0 && !gated && !cnt_sw_wr) |=> (count == '0));

  assert_gated_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gated && !cnt_sw_wr) |=> (count == $past(count) + 1'b1));

endmodule

// File: tb/test_gated_timer.sv
`timescale 1ns/1ps
module test_gated_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_waddr;
  logic [15:0] bus_wdata;
  logic [1:0]  bus_raddr;
  logic [15:0] bus_rdata;
  logic        ext_pin;
  logic        event_flag;
  int          checks = 0;
  int          failures = 0;

  localparam logic [1:0] RC = 2'b00, RN = 2'b01, RP = 2'b10;
  localparam logic [1:0] WR = 2'b00, CL = 2'b01, ST = 2'b10, IV = 2'b11;
  localparam logic [15:0] RUN = 16'h1, SRC = 16'h2, GATE = 16'h4, SYNC = 16'h8, FLG = 16'h40;

  always #2 clk = ~clk;

  gated_timer i_gated_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .ext_pin(ext_pin), .event_flag(event_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] rg, input logic [1:0] op, input logic [15:0] d);
    bus_we = 1'b1; bus_waddr = {rg, op}; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] rg, output logic [15:0] v);
    bus_raddr = rg; #1; v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(RN, v); check("R1 count", v, 16'h0);
    rd(RP, v); check("R1 period", v, 16'hFFFF);
    rd(RC, v); check("R1 ctrl", v, 16'h0);
    check("R1 flag", {15'b0, event_flag}, 16'h0);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    int ratio;
    for (int ps = 0; ps < 4; ps++) begin
      ratio = (ps == 0) ? 1 : (ps == 1) ? 8 : (ps == 2) ? 64 : 256;
      wr(RN, WR, 16'h0);
      wr(RC, WR, RUN | 16'(ps << 4));
      repeat (10*ratio - 1) @(negedge clk);
      wr(RC, CL, RUN);
      rd(RN, v); check(ps == 0 ? "R3 every cycle" : "R4 prescale ratio", v, 16'd10);
    end
    repeat (20) @(negedge clk);
    rd(RN, v); check("R2 hold when stopped", v, 16'd10);
  endtask

  task automatic t_period;
    logic [15:0] v;
    wr(RP, WR, 16'd4);
    wr(RN, WR, 16'h0);
    wr(RC, WR, RUN);
    repeat (1) @(negedge clk);
    wr(RC, CL, RUN);
    rd(RN, v); check("R5 before match", v, 16'd2);
    check("R5 no flag before match", {15'b0, event_flag}, 16'h0);
    wr(RN, WR, 16'h0);
    wr(RC, WR, RUN);
    repeat (10) @(negedge clk);
    wr(RC, CL, RUN);
    rd(RN, v); check("R5 wrap at period", v, 16'd1);
    check("R5 flag set", {15'b0, event_flag}, 16'h1);
    repeat (5) @(negedge clk);
    check("R7 flag sticky", {15'b0, event_flag}, 16'h1);
    wr(RC, CL, FLG);
    check("R7 flag cleared", {15'b0, event_flag}, 16'h0);
  endtask

  task automatic t_zero_period;
    logic [15:0] v;
    wr(RP, WR, 16'h0);
    wr(RN, WR, 16'h0);
    wr(RC, WR, RUN);
    repeat (5) @(negedge clk);
    rd(RN, v); check("R6 count stays zero", v, 16'h0);
    check("R6 flag set", {15'b0, event_flag}, 16'h1);
    wr(RC, CL, FLG);
    check("R7 hardware set wins", {15'b0, event_flag}, 16'h1);
    wr(RC, WR, 16'h0);
    rd(RC, v); check("R7 flag cleared by write", v, 16'h0);
  endtask

  task automatic t_alias;
    logic [15:0] v;
    wr(RP, WR, 16'h00F0);
    wr(RP, ST, 16'h0003);
    rd(RP, v); check("R8 set alias", v, 16'h00F3);
    wr(RP, IV, 16'h0011);
    rd(RP, v); check("R8 invert alias", v, 16'h00E2);
    wr(RP, CL, 16'h00C0);
    rd(RP, v); check("R8 clear alias", v, 16'h0022);
    wr(RN, WR, 16'h1234);
    wr(RN, IV, 16'hFF00);
    rd(RN, v); check("R8 count invert", v, 16'hED34);
    wr(RC, ST, SYNC | SRC);
    rd(RC, v); check("R8 ctrl set", v, 16'h000A);
    wr(RC, WR, 16'h0);
  endtask

  task automatic t_sw_priority;
    logic [15:0] v;
    wr(RP, WR, 16'hFFFF);
    wr(RN, WR, 16'h0);
    wr(RC, WR, RUN);
    repeat (3) @(negedge clk);
    wr(RN, WR, 16'h0100);
    rd(RN, v); check("R13 write beats tick", v, 16'h0100);
    wr(RC, WR, 16'h0);
  endtask

  task automatic t_presc_clear;
    logic [15:0] v;
    wr(RN, WR, 16'h0);
    wr(RC, WR, RUN | 16'h10);
    repeat (4) @(negedge clk);
    wr(RN, WR, 16'h0);
    repeat (7) @(negedge clk);
    rd(RN, v); check("R12 prescaler cleared, no tick yet", v, 16'h0);
    @(negedge clk);
    rd(RN, v); check("R12 tick after full ratio", v, 16'h1);
    wr(RC, WR, 16'h0);
  endtask

  task automatic t_gated;
    logic [15:0] v;
    ext_pin = 1'b0;
    wr(RP, WR, 16'd3);
    wr(RN, WR, 16'h0);
    wr(RC, WR, RUN | GATE);
    repeat (10) @(negedge clk);
    rd(RN, v); check("R9 no count while gate low", v, 16'h0);
    ext_pin = 1'b1;
    repeat (10) @(negedge clk);
    ext_pin = 1'b0;
    rd(RN, v); check("R9 partial window", v, 16'd8);
    check("R9 no flag on match", {15'b0, event_flag}, 16'h0);
    repeat (4) @(negedge clk);
    rd(RN, v); check("R9 full window, no period reset", v, 16'd10);
    check("R9 flag on gate fall", {15'b0, event_flag}, 16'h1);
    wr(RC, WR, 16'h0);
  endtask

  task automatic t_external(input logic sync_on);
    logic [15:0] v;
    ext_pin = 1'b0;
    wr(RP, WR, 16'hFFFF);
    wr(RN, WR, 16'h0);
    wr(RC, WR, RUN | SRC | (sync_on ? SYNC : 16'h0));
    for (int i = 0; i < 5; i++) begin
      ext_pin = 1'b1; repeat (3) @(negedge clk);
      ext_pin = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(RN, v); check(sync_on ? "R10 synced edges" : "R11 raw edges", v, 16'd5);
    wr(RC, WR, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0;
    bus_raddr = '0; ext_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_period();
    t_zero_period();
    t_alias();
    t_sw_priority();
    t_presc_clear();
    t_gated();
    t_external(1'b1);
    t_external(1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule